// File: doc/BRIEF.md
# Interrupt Cause and Mask Controller

This block collects interrupt causes into two banks and raises one interrupt request while any pending cause is also enabled. The first bank holds rare management and error causes. The second bank holds one cause per receive or transmit queue. Each bank has a cause register, a set register that lets software inject causes, and a mask that is opened through a mask-set register and closed through a mask-clear register. The mask-set register also reads back the current mask.

Some registers change state without an explicit software access. On the legacy bank, an access to the cause register can load a programmed acknowledge pattern into the mask. On the extended bank, an auto-mask register selects mask bits that close when the cause register is accessed and open when the set register is written. When MSI-X mode is on, a message-sent pulse clears the cause bits selected by an auto-clear register and closes the mask bits selected by auto-mask. Producing the MSI or MSI-X message itself is done elsewhere.

Software uses a single-cycle register bus. Read data comes back combinationally in the same cycle as the request. Any side effects of that access take hold at the clock edge that ends the cycle.

Top module: `irq_agg_top`

## Requirements
- R1: After synchronous active-low reset, every cause, mask, acknowledge pattern, control, auto-clear and auto-mask register reads 0, and `irq` is low.
- R2: A 1 on a bit of `leg_hw_ev` or `ext_hw_ev` sets that cause bit at the next edge. This holds even when the same cycle clears the bit, whether by a read, a write-1-to-clear or an auto-clear.
- R3: Writing to the legacy set register (address 0x1) or the extended set register (address 0x9) sets every cause bit whose write-data bit is 1.
- R4: A write to a mask-set register (0x2 legacy, 0xA extended) sets the mask bits given by 1s in the data. A read of the same address returns the mask. A write to a mask-clear register (0x3 legacy, 0xB extended) clears the mask bits given by 1s.
- R5: `irq` is high exactly when, in either bank, some bit has both its cause and its mask set.
- R6: A read of a cause register (0x0 legacy, 0x8 extended) returns its current value and clears the whole register at the edge. A write to it clears the bits given by 1s.
- R7: If bit 0 of the legacy control register (0x5) is 1, any read or write of the legacy cause register loads the acknowledge pattern (0x4) into the legacy mask. If bit 0 is 0, the mask is not changed.
- R8: Any read or write of the extended cause register clears the extended mask bits selected by the auto-mask register (0xD).
- R9: A write to the extended set register also sets the extended mask bits selected by auto-mask.
- R10: When `msix_sent` is high and `msix_mode` is high, the extended cause bits selected by auto-clear (0xC) are cleared and the extended mask bits selected by auto-mask are cleared. When `msix_mode` is low, the pulse has no effect. If the same cycle also sets a mask bit, the set wins.
- R11: Addresses 0x4, 0x5, 0xC and 0xD read back what was written to them. The set registers, the clear registers, unused addresses and any cycle that is not a read return 0. Writes to unused addresses change nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| leg_hw_ev | input | LEG_W | Hardware event pulses for the legacy causes |
| ext_hw_ev | input | EXT_W | Hardware event pulses for the per-queue causes |
| msix_mode | input | 1 | MSI-X mode is enabled |
| msix_sent | input | 1 | An MSI-X message was sent in this cycle |
| req_en | input | 1 | Register access in this cycle |
| req_wr | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 4 | Register address |
| req_wdata | input | DATA_W | Write data |
| rd_data | output | DATA_W | Read data for the current access |
| irq | output | 1 | Interrupt request |

## Verification
The assertions inside the cause bank are checked on every cycle. They cover four rules: a hardware event always lands in the cause register, a cause clear that is not overridden really clears, mask-set bits always reach the mask, and mask-clear bits not overridden by a set really close it. The remaining behaviour can only be shown by the bench scenarios: which register access produces which set or clear, the optional acknowledge copy, the auto-mask and auto-clear effects that depend on mode, and the read-back map. For these, a behavioural model is compared with `rd_data` and `irq` on every cycle.

// File: rtl/irq_agg_pkg.sv
// Package: shared register addresses and the decoded-access strobe bundle
// for the interrupt cause and mask controller.
package irq_agg_pkg;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        A_LCAUSE = 4'h0,
        A_LSET   = 4'h1,
        A_LMSET  = 4'h2,
        A_LMCLR  = 4'h3,
        A_LACKM  = 4'h4,
        A_LCTRL  = 4'h5,
        A_ECAUSE = 4'h8,
        A_ESET   = 4'h9,
        A_EMSET  = 4'hA,
        A_EMCLR  = 4'hB,
        A_EACLR  = 4'hC,
        A_EAMSK  = 4'hD
    } reg_addr_e;

    typedef struct packed {
        logic lcause_rd;
        logic lcause_wr;
        logic lset_wr;
        logic lmset_wr;
        logic lmclr_wr;
        logic lackm_wr;
        logic lctrl_wr;
        logic ecause_rd;
        logic ecause_wr;
        logic eset_wr;
        logic emset_wr;
        logic emclr_wr;
        logic eaclr_wr;
        logic eamsk_wr;
    } acc_stb_t;
endpackage

// File: rtl/irq_bus_decode.sv
// Module: irq_bus_decode
// Turns one bus access into a bundle of one-hot access strobes.
// Assumes at most one access per cycle; unused addresses produce no strobe.
module irq_bus_decode
    import irq_agg_pkg::*;
(
    input  logic              req_en,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    output acc_stb_t          stb
);
    // Decode address and direction into exactly one strobe (or none).
    always_comb begin
        stb = '0;
        if (req_en) begin
            case (req_addr)
                A_LCAUSE: begin
                    stb.lcause_rd = !req_wr;
                    stb.lcause_wr = req_wr;
                end
                A_LSET:   stb.lset_wr  = req_wr;
                A_LMSET:  stb.lmset_wr = req_wr;
                A_LMCLR:  stb.lmclr_wr = req_wr;
                A_LACKM:  stb.lackm_wr = req_wr;
                A_LCTRL:  stb.lctrl_wr = req_wr;
                A_ECAUSE: begin
                    stb.ecause_rd = !req_wr;
                    stb.ecause_wr = req_wr;
                end
                A_ESET:   stb.eset_wr  = req_wr;
                A_EMSET:  stb.emset_wr = req_wr;
                A_EMCLR:  stb.emclr_wr = req_wr;
                A_EACLR:  stb.eaclr_wr = req_wr;
                A_EAMSK:  stb.eamsk_wr = req_wr;
                default:  stb = '0;
            endcase
        end
    end
endmodule

// File: rtl/irq_cause_bank.sv
// Module: irq_cause_bank
// One bank of cause bits with a matching mask. Sets beat clears: hardware
// events and software sets win over any clear in the same cycle, and mask
// sets win over mask clears. Assumes the caller has already merged all
// clear and set sources into single vectors.
module irq_cause_bank #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] hw_ev,
    input  logic [W-1:0] c_set,
    input  logic [W-1:0] c_clr,
    input  logic [W-1:0] m_set,
    input  logic [W-1:0] m_clr,
    output logic [W-1:0] cause,
    output logic [W-1:0] mask,
    output logic         pend
);
    // Cause register: clear first, then OR in sets and hardware events.
    always_ff @(posedge clk) begin
        if (!rst_n) cause <= '0;
        else        cause <= (cause & ~c_clr) | c_set | hw_ev;
    end

    // Mask register: clear first, then OR in set bits.
    always_ff @(posedge clk) begin
        if (!rst_n) mask <= '0;
        else        mask <= (mask & ~m_clr) | m_set;
    end

    // Pending when any enabled cause is present.
    assign pend = |(cause & mask);

    // R2: a hardware event is always captured
    a_r2_event_lands: assert property (@(posedge clk) disable iff (!rst_n)
        (hw_ev != '0) |=> ((cause & $past(hw_ev)) == $past(hw_ev)));

    // R6: a clear with no competing set leaves the bit at 0
    a_r6_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_clr & ~c_set & ~hw_ev) != '0) |=>
        ((cause & $past(c_clr & ~c_set & ~hw_ev)) == '0));

    // R4: mask set bits always reach the mask
    a_r4_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
        (m_set != '0) |=> ((mask & $past(m_set)) == $past(m_set)));

    // R4: mask clear bits not overridden close the mask
    a_r4_mask_clr: assert property (@(posedge clk) disable iff (!rst_n)
        ((m_clr & ~m_set) != '0) |=> ((mask & $past(m_clr & ~m_set)) == '0));
endmodule

// File: rtl/irq_agg_top.sv
// Module: irq_agg_top
// Interrupt cause and mask controller with a legacy bank and an extended
// (per-queue) bank. Holds the acknowledge, control, auto-clear and auto-mask
// registers, merges every clear/set source into the two banks, and muxes
// read data. Assumes LEG_W and EXT_W are both below DATA_W.
module irq_agg_top
    import irq_agg_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LEG_W  = 16,
    parameter int EXT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEG_W-1:0]  leg_hw_ev,
    input  logic [EXT_W-1:0]  ext_hw_ev,
    input  logic              msix_mode,
    input  logic              msix_sent,
    input  logic              req_en,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    localparam logic [LEG_W-1:0] L_ALL = {LEG_W{1'b1}};
    localparam logic [EXT_W-1:0] E_ALL = {EXT_W{1'b1}};

    acc_stb_t          stb;
    logic [LEG_W-1:0]  wd_l, lackm, lcause, lmask;
    logic [LEG_W-1:0]  l_cset, l_cclr, l_mset, l_mclr;
    logic [EXT_W-1:0]  wd_e, eaclr, eamsk, ecause, emask;
    logic [EXT_W-1:0]  e_cset, e_cclr, e_mset, e_mclr;
    logic              lctrl_en, l_copy, e_acc, msix_act, l_pend, e_pend;

    irq_bus_decode u_dec (
        .req_en   (req_en),
        .req_wr   (req_wr),
        .req_addr (req_addr),
        .stb      (stb)
    );

    assign wd_l = req_wdata[LEG_W-1:0];
    assign wd_e = req_wdata[EXT_W-1:0];

    // Plain configuration registers written directly by software.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lackm    <= '0;
            lctrl_en <= 1'b0;
            eaclr    <= '0;
            eamsk    <= '0;
        end else begin
            if (stb.lackm_wr) lackm    <= wd_l;
            if (stb.lctrl_wr) lctrl_en <= req_wdata[0];
            if (stb.eaclr_wr) eaclr    <= wd_e;
            if (stb.eamsk_wr) eamsk    <= wd_e;
        end
    end

    // Legacy bank sources: clear-on-read, W1C, optional acknowledge copy.
    always_comb begin
        l_copy = (stb.lcause_rd | stb.lcause_wr) & lctrl_en;
        l_cclr = (stb.lcause_rd ? L_ALL : '0) | (stb.lcause_wr ? wd_l : '0);
        l_cset = stb.lset_wr ? wd_l : '0;
        l_mset = (stb.lmset_wr ? wd_l : '0) | (l_copy ? lackm : '0);
        l_mclr = (stb.lmclr_wr ? wd_l : '0) | (l_copy ? ~lackm : '0);
    end

    // Extended bank sources: access auto-mask, set auto-mask, MSI-X effects.
    always_comb begin
        msix_act = msix_sent & msix_mode;
        e_acc    = stb.ecause_rd | stb.ecause_wr;
        e_cclr   = (stb.ecause_rd ? E_ALL : '0) | (stb.ecause_wr ? wd_e : '0)
                 | (msix_act ? eaclr : '0);
        e_cset   = stb.eset_wr ? wd_e : '0;
        e_mclr   = (stb.emclr_wr ? wd_e : '0) | (e_acc ? eamsk : '0)
                 | (msix_act ? eamsk : '0);
        e_mset   = (stb.emset_wr ? wd_e : '0) | (stb.eset_wr ? eamsk : '0);
    end

    irq_cause_bank #(.W(LEG_W)) u_leg (
        .clk   (clk),
        .rst_n (rst_n),
        .hw_ev (leg_hw_ev),
        .c_set (l_cset),
        .c_clr (l_cclr),
        .m_set (l_mset),
        .m_clr (l_mclr),
        .cause (lcause),
        .mask  (lmask),
        .pend  (l_pend)
    );

    irq_cause_bank #(.W(EXT_W)) u_ext (
        .clk   (clk),
        .rst_n (rst_n),
        .hw_ev (ext_hw_ev),
        .c_set (e_cset),
        .c_clr (e_cclr),
        .m_set (e_mset),
        .m_clr (e_mclr),
        .cause (ecause),
        .mask  (emask),
        .pend  (e_pend)
    );

    assign irq = l_pend | e_pend;

    // Read mux: readable registers zero-extended; everything else returns 0.
    always_comb begin
        rd_data = '0;
        if (req_en && !req_wr) begin
            case (req_addr)
                A_LCAUSE: rd_data[LEG_W-1:0] = lcause;
                A_LMSET:  rd_data[LEG_W-1:0] = lmask;
                A_LACKM:  rd_data[LEG_W-1:0] = lackm;
                A_LCTRL:  rd_data[0]         = lctrl_en;
                A_ECAUSE: rd_data[EXT_W-1:0] = ecause;
                A_EMSET:  rd_data[EXT_W-1:0] = emask;
                A_EACLR:  rd_data[EXT_W-1:0] = eaclr;
                A_EAMSK:  rd_data[EXT_W-1:0] = eamsk;
                default:  rd_data = '0;
            endcase
        end
    end
endmodule

// File: tb/sim_irq_agg_top.sv
// Bench: behavioural reference model updated at each rising edge, compared
// with rd_data and irq half a cycle later on every clock.
module sim_irq_agg_top;
    localparam int DW = 32, LW = 16, EW = 8;

    logic          clk = 1'b0, rst_n = 1'b0;
    logic [LW-1:0] leg_hw_ev = '0;
    logic [EW-1:0] ext_hw_ev = '0;
    logic          msix_mode = 1'b0, msix_sent = 1'b0;
    logic          req_en = 1'b0, req_wr = 1'b0;
    logic [3:0]    req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [DW-1:0] rd_data;
    logic          irq;

    int    n_vec = 0, n_bad = 0;
    string cur_req = "R1";
    bit    started = 0;

    // model state
    logic [LW-1:0] m_lc, m_lm, m_lack;
    logic          m_lctl;
    logic [EW-1:0] m_ec, m_em, m_eac, m_eam;

    always #5 clk = ~clk;

    irq_agg_top #(.DATA_W(DW), .LEG_W(LW), .EXT_W(EW)) u0 (
        .clk(clk), .rst_n(rst_n), .leg_hw_ev(leg_hw_ev), .ext_hw_ev(ext_hw_ev),
        .msix_mode(msix_mode), .msix_sent(msix_sent), .req_en(req_en),
        .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
        .rd_data(rd_data), .irq(irq)
    );

    // Reference model: apply all clears, then all sets, per the requirements.
    always @(posedge clk) begin
        logic [LW-1:0] wl; logic [EW-1:0] we;
        wl = req_wdata[LW-1:0]; we = req_wdata[EW-1:0];
        if (!rst_n) begin
            m_lc = '0; m_lm = '0; m_lack = '0; m_lctl = 0;
            m_ec = '0; m_em = '0; m_eac = '0; m_eam = '0;
            started = 1;
        end else begin
            logic [LW-1:0] lc, lm; logic [EW-1:0] ec, em;
            lc = m_lc; lm = m_lm; ec = m_ec; em = m_em;
            if (msix_sent && msix_mode) begin
                ec = ec & ~m_eac; em = em & ~m_eam;
            end
            if (req_en) begin
                case (req_addr)
                    4'h0: begin
                        lc = req_wr ? (lc & ~wl) : '0;
                        if (m_lctl) lm = m_lack;
                    end
                    4'h1: if (req_wr) lc = lc | wl;
                    4'h2: if (req_wr) lm = lm | wl;
                    4'h3: if (req_wr) lm = lm & ~wl;
                    4'h4: if (req_wr) m_lack = wl;
                    4'h5: if (req_wr) m_lctl = req_wdata[0];
                    4'h8: begin
                        ec = req_wr ? (ec & ~we) : '0;
                        em = em & ~m_eam;
                    end
                    4'hC: if (req_wr) m_eac = we;
                    4'hD: if (req_wr) m_eam = we;
                    default: ;
                endcase
                if (req_wr && req_addr == 4'h9) begin ec = ec | we; em = em | m_eam; end
                if (req_wr && req_addr == 4'hA) em = em | we;
                if (req_wr && req_addr == 4'hB) em = em & ~we;
                if (req_wr && req_addr == 4'hA) em = em | we;
            end
            m_lc = lc | leg_hw_ev; m_lm = lm; m_ec = ec | ext_hw_ev; m_em = em;
        end
    end

    function automatic logic [DW-1:0] exp_rd();
        logic [DW-1:0] r = '0;
        if (req_en && !req_wr)
            case (req_addr)
                4'h0: r[LW-1:0] = m_lc;
                4'h2: r[LW-1:0] = m_lm;
                4'h4: r[LW-1:0] = m_lack;
                4'h5: r[0]      = m_lctl;
                4'h8: r[EW-1:0] = m_ec;
                4'hA: r[EW-1:0] = m_em;
                4'hC: r[EW-1:0] = m_eac;
                4'hD: r[EW-1:0] = m_eam;
                default: r = '0;
            endcase
        return r;
    endfunction

    // Compare on every clock, half a cycle after the edge.
    always @(negedge clk) begin
        #1;
        if (started) begin
            logic exp_irq;
            exp_irq = |(m_lc & m_lm) | |(m_ec & m_em);
            n_vec++;
            if (irq !== exp_irq) begin
                n_bad++;
                $display("FAIL %s/R5 irq: got %0b expected %0b", cur_req, irq, exp_irq);
            end
            n_vec++;
            if (rd_data !== exp_rd()) begin
                n_bad++;
                $display("FAIL %s rd_data @%h: got %h expected %h",
                         cur_req, req_addr, rd_data, exp_rd());
            end
        end
    end

    task automatic op(input bit wr, input logic [3:0] a, input logic [DW-1:0] d);
        @(negedge clk);
        req_en = 1; req_wr = wr; req_addr = a; req_wdata = d;
    endtask

    task automatic idle();
        @(negedge clk);
        req_en = 0; req_wr = 0; req_wdata = '0;
        leg_hw_ev = '0; ext_hw_ev = '0; msix_sent = 0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        cur_req = "R1";
        for (int a = 0; a < 16; a++) op(0, a[3:0], '0);
        idle();
        cur_req = "R4";
        op(1, 4'hA, 32'hF0); op(0, 4'hA, 0); op(1, 4'hB, 32'h30); op(0, 4'hA, 0);
        op(1, 4'h2, 32'hFFFF); op(1, 4'h3, 32'h00FF); op(0, 4'h2, 0); idle();
        cur_req = "R3";
        op(1, 4'h9, 32'h10); idle(); op(1, 4'h1, 32'h0100); op(0, 4'h0, 0); idle();
        cur_req = "R6";
        op(1, 4'h1, 32'h0300); op(0, 4'h0, 0); op(0, 4'h0, 0);
        op(1, 4'h9, 32'h30); op(1, 4'h8, 32'h10); op(0, 4'h8, 0); op(0, 4'h8, 0); idle();
        cur_req = "R2";
        op(1, 4'h9, 32'h01); op(0, 4'h8, 0); ext_hw_ev = 8'h01; leg_hw_ev = 16'h8000;
        idle(); op(1, 4'h0, 32'hFFFF); leg_hw_ev = 16'h8000; idle();
        op(0, 4'h0, 0); op(0, 4'h8, 0); idle();
        cur_req = "R7";
        op(1, 4'h4, 32'h00AA); op(1, 4'h5, 1); op(0, 4'h0, 0); op(0, 4'h2, 0);
        op(1, 4'h5, 0); op(1, 4'h2, 32'hFFFF); op(1, 4'h0, 0); op(0, 4'h2, 0);
        op(0, 4'h4, 0); op(0, 4'h5, 0); idle();
        cur_req = "R8";
        op(1, 4'hD, 32'h0F); op(1, 4'hA, 32'hFF); op(0, 4'h8, 0); op(0, 4'hA, 0); idle();
        cur_req = "R9";
        op(1, 4'h9, 32'h01); op(0, 4'hA, 0); idle();
        cur_req = "R10";
        op(1, 4'hC, 32'h03); op(1, 4'h9, 32'h07); idle();
        msix_sent = 1; idle(); op(0, 4'hA, 0);
        msix_mode = 1; idle(); msix_sent = 1; idle();
        op(0, 4'hA, 0); op(0, 4'hC, 0); idle();
        msix_sent = 1; op(1, 4'hA, 32'h01); idle(); op(0, 4'h8, 0); idle();
        cur_req = "R11";
        op(1, 4'h6, 32'hFFFF); op(1, 4'hF, 32'hFF); op(0, 4'h1, 0); op(0, 4'h3, 0);
        op(0, 4'h9, 0); op(0, 4'hB, 0); op(0, 4'h7, 0); idle();
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            req_en    = ($urandom % 3) != 0;
            req_wr    = $urandom % 2;
            req_addr  = 4'($urandom);
            req_wdata = $urandom;
            leg_hw_ev = (($urandom % 4) == 0) ? LW'($urandom) : '0;
            ext_hw_ev = (($urandom % 4) == 0) ? EW'($urandom) : '0;
            msix_mode = ($urandom % 4) != 0;
            msix_sent = ($urandom % 5) == 0;
        end
        idle(); idle();
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(100000 * 10);
        n_vec++; n_bad++;
        $display("FAIL watchdog %s: got timeout expected completion", cur_req);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule